// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block sits between a software register interface and a byte-level I2C bus engine. Software loads a data buffer, sets a function-control enable, then writes command bits: start, transmit, receive, receive-last and stop. The sequencer carries out the pending commands one at a time. Each one is a single request to the bus engine, and the engine answers with a completion strobe, an acknowledge bit and, for reads, a byte.

Several commands may arrive in one write. They always run in the same fixed order. The block keeps a 4-bit state code that software can read back, and it raises sticky event flags for the interrupt logic. Software clears a flag by writing a 1 to it. A receive is held back while an earlier received byte is still unacknowledged by software. A stop issued with no transfer in progress is reported as abnormal.

Top module: `i2c_cmd_seq`

## Requirements
- R1: Command bits sit at bit0 start, bit1 transmit, bit3 receive, bit4 receive-last and bit5 stop. A command write (`wr_sel`=1) replaces bits 15:0 of the command field. `cmd_status[15:0]` shows the command bits still pending and `cmd_status[22:19]` shows the state code. All other bits read 0, and bits 31:16 of the write data are ignored.
- R2: The commands pending from one write run in this order: start, transmit, receive, stop.
- R3: A start sends `data_buf[7:0]` (address in bits 7:1, read/write flag in bit 0) with `eng_op`=0. While a transfer is active (state bit 3 set) it shows state 0xA, otherwise 0x9. When it finishes, the start and transmit bits are both cleared.
- R4: State codes are 0x0 idle, 0x8 active, 0xB stop, 0xC transmit (`eng_op`=1) and 0xE receive (`eng_op`=2). A successful start, transmit or receive leaves the state at 0x8.
- R5: If the address byte is not acknowledged, TX-NAK (flag bit1) is set and the state becomes 0x0. All remaining command bits are cleared without running.
- R6: A transmit sends `data_buf[7:0]`. An ACK sets TX-ACK (flag bit0) and the state becomes 0x8. A NAK sets TX-NAK, the state becomes 0x0 and the remaining commands are dropped.
- R7: A receive stores the returned byte in `data_buf[15:8]` and sets RX-done (flag bit2). It requests a NAK (`eng_nak_last`=1) when receive-last is set. Both receive bits are then cleared.
- R8: A receive pending while RX-done is set issues no request and blocks the commands after it. It runs once software clears RX-done.
- R9: A stop with the state at 0x8 issues `eng_op`=3 in state 0xB, then sets normal-stop (flag bit3). A stop in any other state issues no request and sets abnormal (flag bit4). In both cases the state ends at 0x0.
- R10: Command writes are ignored unless bit0 or bit1 of the function-control register (`wr_sel`=0) is set.
- R11: `busy` is high while an engine request is outstanding, and the request is held until `eng_done`. A command write made while busy takes effect when the current operation completes.
- R12: A flag write (`wr_sel`=3) clears each flag whose data bit is 1 and leaves the others unchanged. A data write (`wr_sel`=2) loads `data_buf[7:0]` and zeroes `data_buf[15:8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 function control, 1 command, 2 data buffer, 3 flag clear |
| wr_data | input | 32 | Write data |
| cmd_status | output | 32 | Pending command bits and state code |
| data_buf | output | 16 | Received byte (15:8) and transmit byte (7:0) |
| flags | output | 5 | Event flags: TX-ACK, TX-NAK, RX-done, normal stop, abnormal |
| busy | output | 1 | Engine request outstanding |
| eng_req | output | 1 | Request to the bus engine |
| eng_op | output | 2 | Operation: 0 start, 1 transmit, 2 receive, 3 stop |
| eng_wbyte | output | 8 | Byte to send |
| eng_nak_last | output | 1 | NAK the byte being received |
| eng_done | input | 1 | Operation complete strobe |
| eng_ack | input | 1 | Acknowledge observed (1 = ACK) |
| eng_rbyte | input | 8 | Received byte |

## Verification
The sequencer is exercised with single commands, with one write carrying start, receive-last and stop, and with writes that combine commands with an address or data NAK. Comparing the recorded engine operations and the state codes they were issued under separates correct ordering from reordering, and separates the repeated-start code from the plain start code. The mix also shows whether a NAK cancels the commands queued behind it. A held receive, a write made while busy and a write with the block disabled each test when commands are accepted, rather than only what they do. Stops with and without an active transfer distinguish the normal-stop and abnormal outcomes.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int CMD_W   = 16;
  localparam int BYTE_W  = 8;
  localparam int ST_W    = 4;
  localparam int FLAG_N  = 5;
  localparam int ST_LSB  = 19;

  localparam int C_START = 0;
  localparam int C_TX    = 1;
  localparam int C_RX    = 3;
  localparam int C_LAST  = 4;
  localparam int C_STOP  = 5;

  localparam int F_TXACK = 0;
  localparam int F_TXNAK = 1;
  localparam int F_RXD   = 2;
  localparam int F_STOP  = 3;
  localparam int F_ABN   = 4;

  localparam logic [ST_W-1:0] ST_IDLE = 4'h0;
  localparam logic [ST_W-1:0] ST_ACT  = 4'h8;
  localparam logic [ST_W-1:0] ST_STA  = 4'h9;
  localparam logic [ST_W-1:0] ST_RSTA = 4'hA;
  localparam logic [ST_W-1:0] ST_STP  = 4'hB;
  localparam logic [ST_W-1:0] ST_TXD  = 4'hC;
  localparam logic [ST_W-1:0] ST_RXD  = 4'hE;

  typedef enum logic [2:0] {
    OP_NONE, OP_HOLD, OP_START, OP_TX, OP_RX, OP_STOP
  } op_e;

  // Fixed priority among pending command bits.
  function automatic op_e pick_op(input logic [CMD_W-1:0] c, input logic rx_done);
    if (c[C_START])               return OP_START;
    if (c[C_TX])                  return OP_TX;
    if (c[C_RX] || c[C_LAST])     return rx_done ? OP_HOLD : OP_RX;
    if (c[C_STOP])                return OP_STOP;
    return OP_NONE;
  endfunction

  function automatic logic [1:0] op_code(input op_e op);
    case (op)
      OP_START: return 2'd0;
      OP_TX:    return 2'd1;
      OP_RX:    return 2'd2;
      default:  return 2'd3;
    endcase
  endfunction

  function automatic logic [ST_W-1:0] launch_state(input op_e op, input logic [ST_W-1:0] cur);
    case (op)
      OP_START: return cur[3] ? ST_RSTA : ST_STA;
      OP_TX:    return ST_TXD;
      OP_RX:    return ST_RXD;
      default:  return ST_STP;
    endcase
  endfunction
endpackage

// File: rtl/i2cs_flags.sv
module i2cs_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flags_o[i] <= 1'b0;
      else if (set_i[i]) flags_o[i] <= 1'b1;
      else if (clr_i[i]) flags_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cs_decode.sv
module i2cs_decode
  import i2cs_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             rx_done_i,
  input  logic [ST_W-1:0]  state_i,
  input  logic             idle_i,
  output op_e              op_o,
  output logic             launch_o,
  output logic             abn_stop_o
);
  always_comb begin
    op_o       = pick_op(cmd_i, rx_done_i);
    launch_o   = 1'b0;
    abn_stop_o = 1'b0;
    if (idle_i) begin
      case (op_o)
        OP_START, OP_TX, OP_RX: launch_o = 1'b1;
        OP_STOP: begin
          launch_o   = state_i[3];
          abn_stop_o = !state_i[3];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2cs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] cmd_status,
  output logic [15:0] data_buf,
  output logic [4:0]  flags,
  output logic        busy,
  output logic        eng_req,
  output logic [1:0]  eng_op,
  output logic [7:0]  eng_wbyte,
  output logic        eng_nak_last,
  input  logic        eng_done,
  input  logic        eng_ack,
  input  logic [7:0]  eng_rbyte
);
  localparam logic [1:0] SEL_FUN = 2'd0;
  localparam logic [1:0] SEL_CMD = 2'd1;
  localparam logic [1:0] SEL_DAT = 2'd2;
  localparam logic [1:0] SEL_FLG = 2'd3;

  logic [1:0]        en_q;
  logic [CMD_W-1:0]  cmd_q, cmd_d, clr_bits;
  logic [CMD_W-1:0]  park_val;
  logic              park_vld;
  logic [ST_W-1:0]   state_q;
  logic [2*BYTE_W-1:0] buf_q;
  op_e               op_sel, op_q;
  logic              launch, abn_stop, fin, fin_ok, cmd_wr;
  logic [FLAG_N-1:0] f_set, f_clr;

  assign cmd_wr = wr_en && (wr_sel == SEL_CMD) && (|en_q);
  assign fin    = eng_req && eng_done;
  assign fin_ok = fin && eng_ack;

  i2cs_decode u_dec (
    .cmd_i(cmd_q), .rx_done_i(flags[F_RXD]), .state_i(state_q),
    .idle_i(!eng_req), .op_o(op_sel), .launch_o(launch), .abn_stop_o(abn_stop)
  );

  i2cs_flags #(.N(FLAG_N)) u_flg (
    .clk(clk), .rst_n(rst_n), .set_i(f_set), .clr_i(f_clr), .flags_o(flags)
  );

  always_comb begin
    clr_bits = '0;
    f_set    = '0;
    f_clr    = (wr_en && wr_sel == SEL_FLG) ? wr_data[FLAG_N-1:0] : '0;
    if (abn_stop) begin
      clr_bits[C_STOP] = 1'b1;
      f_set[F_ABN]     = 1'b1;
    end
    if (fin) begin
      case (op_q)
        OP_START, OP_TX: begin
          clr_bits[C_TX] = 1'b1;
          if (op_q == OP_START) clr_bits[C_START] = 1'b1;
          if (eng_ack) f_set[F_TXACK] = 1'b1;
          else begin
            f_set[F_TXNAK] = 1'b1;
            clr_bits = clr_bits | (CMD_W'(1) << C_RX) | (CMD_W'(1) << C_LAST)
                     | (CMD_W'(1) << C_STOP) | (CMD_W'(1) << C_START);
          end
        end
        OP_RX: begin
          clr_bits[C_RX]   = 1'b1;
          clr_bits[C_LAST] = 1'b1;
          f_set[F_RXD]     = 1'b1;
        end
        default: begin
          clr_bits[C_STOP] = 1'b1;
          f_set[F_STOP]    = 1'b1;
        end
      endcase
    end
    if (cmd_wr && (!eng_req || eng_done)) cmd_d = wr_data[CMD_W-1:0];
    else if (fin && park_vld)             cmd_d = park_val;
    else                                  cmd_d = cmd_q & ~clr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; cmd_q <= '0; park_val <= '0; park_vld <= 1'b0;
      state_q <= ST_IDLE; buf_q <= '0; op_q <= OP_NONE;
      eng_req <= 1'b0; eng_op <= '0; eng_wbyte <= '0; eng_nak_last <= 1'b0;
    end else begin
      cmd_q <= cmd_d;
      if (wr_en && wr_sel == SEL_FUN) en_q <= wr_data[1:0];
      if (cmd_wr && eng_req && !eng_done) begin
        park_vld <= 1'b1;
        park_val <= wr_data[CMD_W-1:0];
      end else if (fin) begin
        park_vld <= 1'b0;
      end
      if (fin && op_q == OP_RX) buf_q[2*BYTE_W-1:BYTE_W] <= eng_rbyte;
      if (wr_en && wr_sel == SEL_DAT) buf_q <= {{BYTE_W{1'b0}}, wr_data[BYTE_W-1:0]};
      if (launch) begin
        eng_req      <= 1'b1;
        op_q         <= op_sel;
        eng_op       <= op_code(op_sel);
        eng_wbyte    <= buf_q[BYTE_W-1:0];
        eng_nak_last <= cmd_q[C_LAST];
        state_q      <= launch_state(op_sel, state_q);
      end else if (abn_stop) begin
        state_q <= ST_IDLE;
      end else if (fin) begin
        eng_req <= 1'b0;
        case (op_q)
          OP_START, OP_TX: state_q <= fin_ok ? ST_ACT : ST_IDLE;
          OP_RX:           state_q <= ST_ACT;
          default:         state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy       = eng_req;
  assign data_buf   = buf_q;
  assign cmd_status = {{(32-ST_LSB-ST_W){1'b0}}, state_q, {(ST_LSB-CMD_W){1'b0}}, cmd_q};
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       eng_req,
  input logic       eng_done,
  input logic [1:0] eng_op,
  input logic [3:0] state_code,
  input logic [4:0] flags
);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && !eng_done |=> eng_req);
  p_req_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && eng_done |=> !eng_req);
  p_start_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && eng_op == 2'd0 |-> (state_code == 4'h9 || state_code == 4'hA));
  p_tx_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && eng_op == 2'd1 |-> state_code == 4'hC);
  p_rx_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && eng_op == 2'd2 |-> state_code == 4'hE);
  p_stop_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && eng_op == 2'd3 |-> state_code == 4'hB);
  p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[3]) |-> state_code == 4'h0);
  p_abn_noreq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[4]) |-> !eng_req && state_code == 4'h0);
  p_rxdone_act_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[2]) |-> state_code == 4'h8);
endmodule

bind i2c_cmd_seq i2cs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .eng_req(eng_req), .eng_done(eng_done),
  .eng_op(eng_op), .state_code(state_q), .flags(flags)
);

// File: tb/i2c_cmd_seq_test.sv
module i2c_cmd_seq_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] cmd_status;
  logic [15:0] data_buf;
  logic [4:0]  flags;
  logic        busy, eng_req, eng_nak_last;
  logic [1:0]  eng_op;
  logic [7:0]  eng_wbyte;
  logic        eng_done = 1'b0, eng_ack = 1'b0;
  logic [7:0]  eng_rbyte = '0;

  int checks = 0, fails = 0;
  int lat = 2;
  logic addr_ack = 1'b1, data_ack = 1'b1;
  logic [7:0] rx_val = 8'h5A;
  int lg_n = 0;
  logic [1:0] lg_op [0:31];
  logic [7:0] lg_byte [0:31];
  logic       lg_last [0:31];
  logic [3:0] lg_st [0:31];

  always #10 clk = ~clk;

  i2c_cmd_seq uut (.*);

  // Behavioural bus engine: logs each request, answers after lat cycles.
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (eng_done) eng_done = 1'b0;
      else if (eng_req) begin
        if (cnt == 0 && lg_n < 32) begin
          lg_op[lg_n] = eng_op; lg_byte[lg_n] = eng_wbyte;
          lg_last[lg_n] = eng_nak_last; lg_st[lg_n] = cmd_status[22:19];
          lg_n++;
        end
        cnt++;
        if (cnt >= lat) begin
          cnt = 0;
          eng_done = 1'b1;
          eng_ack = (eng_op == 2'd0) ? addr_ack : (eng_op == 2'd1) ? data_ack : 1'b1;
          eng_rbyte = rx_val;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (60) @(negedge clk);
  endtask

  task automatic chk_log(input string tag, input int i, input logic [1:0] op,
                         input logic [7:0] b, input logic [3:0] st);
    chk({tag, " op"}, 32'(lg_op[i]), 32'(op));
    if (op <= 2'd1) chk({tag, " byte"}, 32'(lg_byte[i]), 32'(b));
    chk({tag, " state"}, 32'(lg_st[i]), 32'(st));
  endtask

  task automatic t_reset();
    chk("R1 reset cmd_status", cmd_status, 32'h0);
    chk("R12 reset flags", 32'(flags), 32'h0);
    chk("R11 reset busy", 32'(busy), 32'h0);
  endtask

  task automatic t_disabled();
    wr(2'd1, 32'h0000_0021);
    settle();
    chk("R10 disabled cmd ignored", cmd_status, 32'h0);
    chk("R10 disabled no request", 32'(lg_n), 32'd0);
  endtask

  task automatic t_start();
    wr(2'd0, 32'h1);
    wr(2'd2, 32'hA4);
    wr(2'd1, 32'h1);
    settle();
    chk_log("R3 start", 0, 2'd0, 8'hA4, 4'h9);
    chk("R4 start then active", cmd_status, 32'h0040_0000);
    chk("R6 addr ack flag", 32'(flags), 32'h01);
  endtask

  task automatic t_tx();
    int b = lg_n;
    wr(2'd3, 32'h1F);
    wr(2'd2, 32'h3C);
    wr(2'd1, 32'h2);
    settle();
    chk_log("R6 tx", b, 2'd1, 8'h3C, 4'hC);
    chk("R6 tx ack state", cmd_status, 32'h0040_0000);
    chk("R6 tx ack flag", 32'(flags), 32'h01);
  endtask

  task automatic t_multi();
    int b = lg_n;
    wr(2'd3, 32'h1F);
    wr(2'd2, 32'hA5);
    rx_val = 8'h96;
    wr(2'd1, 32'h39);
    settle();
    chk("R2 op count", 32'(lg_n - b), 32'd3);
    chk_log("R3 repeated start", b, 2'd0, 8'hA5, 4'hA);
    chk_log("R2 rx second", b + 1, 2'd2, 8'h0, 4'hE);
    chk("R7 nak last", 32'(lg_last[b + 1]), 32'h1);
    chk_log("R9 stop third", b + 2, 2'd3, 8'h0, 4'hB);
    chk("R7 rx byte", 32'(data_buf), 32'h96A5);
    chk("R9 flags", 32'(flags), 32'h0D);
    chk("R9 idle after stop", cmd_status, 32'h0);
  endtask

  task automatic t_abnormal();
    int b = lg_n;
    wr(2'd3, 32'h1F);
    wr(2'd1, 32'h20);
    settle();
    chk("R9 abnormal no request", 32'(lg_n - b), 32'd0);
    chk("R9 abnormal flag", 32'(flags), 32'h10);
    chk("R9 abnormal state", cmd_status, 32'h0);
  endtask

  task automatic t_addr_nak();
    int b = lg_n;
    wr(2'd3, 32'h1F);
    addr_ack = 1'b0;
    wr(2'd2, 32'hB0);
    wr(2'd1, 32'h23);
    settle();
    addr_ack = 1'b1;
    chk("R5 only start ran", 32'(lg_n - b), 32'd1);
    chk("R5 nak flag", 32'(flags), 32'h02);
    chk("R5 dropped and idle", cmd_status, 32'h0);
  endtask

  task automatic t_tx_nak();
    int b = lg_n;
    wr(2'd3, 32'h1F);
    wr(2'd2, 32'hA4);
    wr(2'd1, 32'h1);
    settle();
    data_ack = 1'b0;
    wr(2'd1, 32'h22);
    settle();
    data_ack = 1'b1;
    chk("R6 tx nak ops", 32'(lg_n - b), 32'd2);
    chk("R6 tx nak flags", 32'(flags), 32'h03);
    chk("R6 tx nak idle dropped", cmd_status, 32'h0);
  endtask

  task automatic t_busy_write();
    int b = lg_n;
    lat = 10;
    wr(2'd3, 32'h1F);
    wr(2'd2, 32'hA4);
    wr(2'd1, 32'h1);
    repeat (3) @(negedge clk);
    chk("R11 busy during op", 32'(busy), 32'h1);
    wr(2'd1, 32'h2);
    settle();
    lat = 2;
    chk("R11 both ran", 32'(lg_n - b), 32'd2);
    chk_log("R11 parked tx", b + 1, 2'd1, 8'hA4, 4'hC);
    chk("R11 end active", cmd_status, 32'h0040_0000);
  endtask

  task automatic t_rx_hold();
    int b;
    rx_val = 8'h11;
    wr(2'd1, 32'h08);
    settle();
    chk("R7 rx single", 32'(data_buf), 32'h11A4);
    b = lg_n;
    rx_val = 8'h22;
    wr(2'd1, 32'h28);
    settle();
    chk("R8 held no request", 32'(lg_n - b), 32'd0);
    chk("R8 held pending", cmd_status, 32'h0040_0028);
    wr(2'd3, 32'h04);
    settle();
    chk("R8 released ops", 32'(lg_n - b), 32'd2);
    chk_log("R8 rx after clear", b, 2'd2, 8'h0, 4'hE);
    chk("R8 rx nak not last", 32'(lg_last[b]), 32'h0);
    chk("R8 new byte", 32'(data_buf), 32'h22A4);
    chk("R8 stop after rx", cmd_status, 32'h0);
  endtask

  task automatic t_flags();
    logic [4:0] f0 = flags;
    wr(2'd3, 32'h01);
    chk("R12 w1c one bit", 32'(flags), 32'(f0 & 5'h1E));
    wr(2'd1, 32'hFFC0_0000);
    settle();
    chk("R1 upper write bits ignored", cmd_status, 32'h0);
    wr(2'd2, 32'h1_23C7);
    chk("R12 data write clears rx field", 32'(data_buf), 32'h00C7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_start();
    t_tx();
    t_multi();
    t_abnormal();
    t_addr_nak();
    t_tx_nak();
    t_busy_write();
    t_rx_hold();
    t_flags();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R11 watchdog actual=hung expected=complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule